// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block divides a fast input clock by a programmable total ratio P·N + A. A prescaler with two neighbouring moduli, P and P+1, is steered by two counters. The swallow count A sets how many prescaler periods in each output cycle use the longer modulus P+1. The main count N sets how many prescaler periods make up one output cycle. The low modulus P is either 32 or 64, picked by a single select input. The block emits one short pulse per completed output cycle. That pulse is the feedback edge for a phase/frequency comparator in a frequency synthesizer loop.

Everything is synchronous to the divided clock itself. New ratio inputs are taken only at the edge that closes an output cycle, so no cycle is ever built from two different settings. Settings that the counters cannot realise are forced to legal values. A swallow count larger than the main count is one such setting, and it is reported on a flag output.

Top module: `psd_divider`

## Requirements
- R1: With `p_sel`=1 and A ≤ N, consecutive `fp` pulses are exactly 32·N + A `fin` cycles apart, for every A from 0 up to and including A = N.
- R2: With `p_sel`=0 and A ≤ N, the spacing between consecutive `fp` pulses is exactly 64·N + A `fin` cycles.
- R3: `fp` is high for exactly one `fin` cycle per output cycle and is low in the cycle after every pulse.
- R4: When `swallow_cnt` exceeds the effective main count, A is clamped to that count, so the spacing becomes P·N + N. `ratio_clamped` is high for exactly those output cycles and low otherwise. The flag updates on the same edge that raises `fp`.
- R5: A `main_cnt` value below 16 is treated as 16. The clamp of R4 then compares against 16.
- R6: `p_sel`, `swallow_cnt` and `main_cnt` are sampled only on the `fin` edge that raises `fp`. Any value held between two such edges, including values changed and restored mid-cycle, has no effect on the cycle in progress.
- R7: While `rst_n` is low, `fp` and `ratio_clamped` are low. Reset assertion takes effect without a clock edge. Release is retimed over two `fin` edges. The settings are loaded on the third edge, and the first `fp` follows one full output cycle later, 3 + P·N + A edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fin | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| p_sel | input | 1 | Prescaler pair select: 1 gives 32/33, 0 gives 64/65 |
| swallow_cnt | input | 7 | Swallow count A, 0 to 127 |
| main_cnt | input | 11 | Main count N, 16 to 2047 |
| fp | output | 1 | One-cycle pulse closing each output cycle |
| ratio_clamped | output | 1 | High while the active cycle uses a clamped swallow count |

## Verification
The assertions rely on the internal count state being consistent, not on input legality. The swallow remainder must stay below the main remainder, the prescaler count must stay within the larger modulus, and the main count must never reach zero. These hold because the ratio selector clamps before loading, so the stimulus may drive out-of-range values on purpose. The pulse-width and flag-hold properties assume that the shortest output cycle (32·16 cycles) is far longer than one cycle. The stimulus changes inputs only right after an `fp` sample or well inside a cycle, and each change is restored before the closing edge when the test needs that.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned PSD_A_W     = 7;
  localparam int unsigned PSD_N_W     = 11;
  localparam int unsigned PSD_P_SMALL = 32;
  localparam int unsigned PSD_P_LARGE = 64;
  localparam int unsigned PSD_N_MIN   = 16;

  typedef enum logic {
    PSEL_LARGE = 1'b0,
    PSEL_SMALL = 1'b1
  } psel_e;
endpackage

// File: rtl/psd_rst_sync.sv
module psd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/psd_ratio_sel.sv
module psd_ratio_sel
  import psd_pkg::*;
#(
  parameter int unsigned A_W     = PSD_A_W,
  parameter int unsigned N_W     = PSD_N_W,
  parameter int unsigned PC_W    = 7,
  parameter int unsigned P_SMALL = PSD_P_SMALL,
  parameter int unsigned P_LARGE = PSD_P_LARGE,
  parameter int unsigned N_MIN   = PSD_N_MIN
) (
  input  logic           sel_small,
  input  logic [A_W-1:0] a_in,
  input  logic [N_W-1:0] n_in,
  output logic [PC_W-1:0] p_o,
  output logic [A_W-1:0] a_o,
  output logic [N_W-1:0] n_o,
  output logic           clamp_o
);
  localparam logic [N_W-1:0]  N_FLOOR = N_W'(N_MIN);
  localparam logic [PC_W-1:0] P_LO_S  = PC_W'(P_SMALL);
  localparam logic [PC_W-1:0] P_LO_L  = PC_W'(P_LARGE);

  logic [N_W-1:0] a_wide;
  psel_e          psel;

  always_comb begin
    psel    = psel_e'(sel_small);
    p_o     = (psel == PSEL_SMALL) ? P_LO_S : P_LO_L;
    n_o     = (n_in < N_FLOOR) ? N_FLOOR : n_in;
    a_wide  = N_W'(a_in);
    clamp_o = (a_wide > n_o);
    a_o     = clamp_o ? A_W'(n_o) : a_in;
  end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned PC_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] load_val,
  output logic            period_end,
  output logic [PC_W-1:0] cnt_o
);
  logic [PC_W-1:0] cnt_q;
  logic [PC_W-1:0] cnt_d;

  always_comb begin
    period_end = (cnt_q == '0);
    cnt_d      = period_end ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/psd_cycle_ctrl.sv
module psd_cycle_ctrl #(
  parameter int unsigned A_W  = 7,
  parameter int unsigned N_W  = 11,
  parameter int unsigned PC_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            period_end,
  input  logic [PC_W-1:0] p_new,
  input  logic [A_W-1:0]  a_new,
  input  logic [N_W-1:0]  n_new,
  input  logic            clamp_new,
  output logic [PC_W-1:0] pc_load,
  output logic            fp_o,
  output logic            clamp_o,
  output logic            primed_o,
  output logic [N_W-1:0]  nc_o,
  output logic [A_W-1:0]  sc_o
);
  logic [N_W-1:0]  nc_q, nc_d;
  logic [A_W-1:0]  sc_q, sc_d;
  logic [PC_W-1:0] p_q, p_d;
  logic            clamp_q, clamp_d;
  logic            primed_q, primed_d;
  logic            fp_q, fp_d;
  logic            reload;
  logic            cnt_en;

  always_comb begin
    cnt_en   = period_end;
    reload   = period_end && (nc_q == N_W'(1));
    nc_d     = nc_q;
    sc_d     = sc_q;
    p_d      = p_q;
    clamp_d  = clamp_q;
    primed_d = primed_q;
    fp_d     = 1'b0;
    pc_load  = p_q - 1'b1;
    if (reload) begin
      nc_d     = n_new;
      p_d      = p_new;
      clamp_d  = clamp_new;
      primed_d = 1'b1;
      fp_d     = primed_q;
      if (a_new != '0) begin
        sc_d    = a_new - 1'b1;
        pc_load = p_new;
      end else begin
        sc_d    = '0;
        pc_load = p_new - 1'b1;
      end
    end else if (period_end) begin
      nc_d = nc_q - 1'b1;
      if (sc_q != '0) begin
        sc_d    = sc_q - 1'b1;
        pc_load = p_q;
      end else begin
        pc_load = p_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nc_q     <= N_W'(1);
      sc_q     <= '0;
      p_q      <= '0;
      clamp_q  <= 1'b0;
      primed_q <= 1'b0;
      fp_q     <= 1'b0;
    end else begin
      fp_q <= fp_d;
      if (cnt_en) begin
        nc_q     <= nc_d;
        sc_q     <= sc_d;
        p_q      <= p_d;
        clamp_q  <= clamp_d;
        primed_q <= primed_d;
      end
    end
  end

  assign fp_o     = fp_q;
  assign clamp_o  = clamp_q;
  assign primed_o = primed_q;
  assign nc_o     = nc_q;
  assign sc_o     = sc_q;
endmodule

// File: rtl/psd_divider.sv
module psd_divider
  import psd_pkg::*;
#(
  parameter int unsigned A_W     = PSD_A_W,
  parameter int unsigned N_W     = PSD_N_W,
  parameter int unsigned P_SMALL = PSD_P_SMALL,
  parameter int unsigned P_LARGE = PSD_P_LARGE,
  parameter int unsigned N_MIN   = PSD_N_MIN,
  parameter int unsigned RST_STG = 2
) (
  input  logic           fin,
  input  logic           rst_n,
  input  logic           p_sel,
  input  logic [A_W-1:0] swallow_cnt,
  input  logic [N_W-1:0] main_cnt,
  output logic           fp,
  output logic           ratio_clamped
);
  localparam int unsigned PC_W = $clog2(P_LARGE + 1);

  logic            rst_sync_n;
  logic [PC_W-1:0] p_sel_val;
  logic [A_W-1:0]  a_eff;
  logic [N_W-1:0]  n_eff;
  logic            clamp_sel;
  logic [PC_W-1:0] pc_load;
  logic            period_end;
  logic [PC_W-1:0] pc_w;
  logic            primed_w;
  logic [N_W-1:0]  nc_w;
  logic [A_W-1:0]  sc_w;

  psd_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk     (fin),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  psd_ratio_sel #(
    .A_W(A_W), .N_W(N_W), .PC_W(PC_W),
    .P_SMALL(P_SMALL), .P_LARGE(P_LARGE), .N_MIN(N_MIN)
  ) u_sel (
    .sel_small (p_sel),
    .a_in      (swallow_cnt),
    .n_in      (main_cnt),
    .p_o       (p_sel_val),
    .a_o       (a_eff),
    .n_o       (n_eff),
    .clamp_o   (clamp_sel)
  );

  psd_prescaler #(.PC_W(PC_W)) u_pre (
    .clk        (fin),
    .rst_n      (rst_sync_n),
    .load_val   (pc_load),
    .period_end (period_end),
    .cnt_o      (pc_w)
  );

  psd_cycle_ctrl #(.A_W(A_W), .N_W(N_W), .PC_W(PC_W)) u_ctrl (
    .clk        (fin),
    .rst_n      (rst_sync_n),
    .period_end (period_end),
    .p_new      (p_sel_val),
    .a_new      (a_eff),
    .n_new      (n_eff),
    .clamp_new  (clamp_sel),
    .pc_load    (pc_load),
    .fp_o       (fp),
    .clamp_o    (ratio_clamped),
    .primed_o   (primed_w),
    .nc_o       (nc_w),
    .sc_o       (sc_w)
  );
endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk #(
  parameter int unsigned A_W     = 7,
  parameter int unsigned N_W     = 11,
  parameter int unsigned PC_W    = 7,
  parameter int unsigned P_LARGE = 64,
  parameter int unsigned N_MIN   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fp,
  input logic            clamp,
  input logic            primed,
  input logic [PC_W-1:0] pc,
  input logic [N_W-1:0]  nc,
  input logic [A_W-1:0]  sc
);
  assert_fp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> !fp);

  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && !fp) |-> $stable(clamp));

  assert_swallow_below_main_R1: assert property (@(posedge clk) disable iff (!rst_n)
    N_W'(sc) < nc);

  assert_pc_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= PC_W'(P_LARGE));

  assert_main_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fp |-> (nc >= N_W'(N_MIN)));

  assert_main_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nc != '0);
endmodule

bind psd_divider psd_divider_chk #(
  .A_W(A_W), .N_W(N_W), .PC_W(PC_W), .P_LARGE(P_LARGE), .N_MIN(N_MIN)
) u_chk (
  .clk    (fin),
  .rst_n  (rst_sync_n),
  .fp     (fp),
  .clamp  (ratio_clamped),
  .primed (primed_w),
  .pc     (pc_w),
  .nc     (nc_w),
  .sc     (sc_w)
);

// File: tb/tb_psd_divider.sv
module tb_psd_divider;
  logic        fin = 1'b0;
  logic        rst_n;
  logic        p_sel;
  logic [6:0]  swallow_cnt;
  logic [10:0] main_cnt;
  logic        fp;
  logic        ratio_clamped;

  int n_checks = 0;
  int n_bad    = 0;
  int prev_total;
  bit hung     = 1'b0;

  always #10 fin = ~fin;

  psd_divider dut (
    .fin           (fin),
    .rst_n         (rst_n),
    .p_sel         (p_sel),
    .swallow_cnt   (swallow_cnt),
    .main_cnt      (main_cnt),
    .fp            (fp),
    .ratio_clamped (ratio_clamped)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_fp(output int cnt);
    cnt = 0;
    do begin
      @(negedge fin);
      cnt++;
    end while (!fp && cnt < 20000);
    if (!fp) begin
      hung = 1'b1;
      n_checks++;
      n_bad++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", cnt, 0);
    end
  endtask

  task automatic step(input bit s, input int a, input int n);
    int p, ne, ae, total, c;
    bit flag;
    string tag;
    if (hung) return;
    p     = s ? 32 : 64;
    ne    = (n < 16) ? 16 : n;
    flag  = (a > ne);
    ae    = flag ? ne : a;
    total = p * ne + ae;
    if (n < 16)     tag = "R5 low main count";
    else if (flag)  tag = "R4 clamped spacing";
    else if (s)     tag = "R1 spacing p=32";
    else            tag = "R2 spacing p=64";
    p_sel       = s;
    swallow_cnt = 7'(a);
    main_cnt    = 11'(n);
    wait_fp(c);
    if (hung) return;
    check(c == prev_total, "R6 old ratio kept", c, prev_total);
    check(ratio_clamped == flag, "R4 clamp flag", int'(ratio_clamped), int'(flag));
    @(negedge fin);
    check(fp == 1'b0, "R3 pulse width", int'(fp), 0);
    wait_fp(c);
    if (hung) return;
    c = c + 1;
    check(c == total, tag, c, total);
    prev_total = total;
  endtask

  initial begin
    int c;
    rst_n       = 1'b0;
    p_sel       = 1'b1;
    swallow_cnt = 7'd0;
    main_cnt    = 11'd16;
    repeat (3) @(negedge fin);
    check(fp == 1'b0, "R7 fp in reset", int'(fp), 0);
    check(ratio_clamped == 1'b0, "R7 flag in reset", int'(ratio_clamped), 0);
    rst_n = 1'b1;
    wait_fp(c);
    check(c == 515, "R7 first pulse", c, 515);
    wait_fp(c);
    check(c == 512, "R1 spacing p=32 a=0", c, 512);
    prev_total = 512;

    for (int a = 0; a <= 18; a++) step(1'b1, a, 16);
    for (int a = 0; a <= 17; a++) step(1'b0, a, 16);
    step(1'b1, 0, 20);
    step(1'b1, 20, 20);
    step(1'b0, 21, 20);
    step(1'b1, 5, 3);
    step(1'b1, 127, 3);
    step(1'b0, 127, 100);
    step(1'b1, 100, 100);

    if (!hung) begin
      repeat (100) @(negedge fin);
      p_sel       = 1'b0;
      swallow_cnt = 7'd99;
      main_cnt    = 11'd1500;
      repeat (100) @(negedge fin);
      p_sel       = 1'b1;
      swallow_cnt = 7'd100;
      main_cnt    = 11'd100;
      wait_fp(c);
      c = c + 200;
      check(c == 3300, "R6 mid-cycle change ignored", c, 3300);
    end

    step(1'b1, 40, 16);
    @(negedge fin);
    rst_n = 1'b0;
    #1;
    check(ratio_clamped == 1'b0, "R7 async flag clear", int'(ratio_clamped), 0);
    check(fp == 1'b0, "R7 async fp clear", int'(fp), 0);

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge fin);
    n_checks++;
    n_bad++;
    $display("FAIL R3 global watchdog actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule